// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when a backup battery is tested and keeps the outcome. An external comparator reports, as one digital flag, whether the battery sits below its low threshold (about 2.5 V). The block does not watch that flag all the time. It samples the flag only at scheduled test instants. One test runs each time main power becomes valid. Further tests follow at a fixed long interval for as long as main power stays valid. The interval is counted on a slow tick input, so a simulation can use a short interval and silicon can use a day.

Each test raises a one-cycle request strobe that wakes the comparator. After a parameterised settle delay, the block reads the flag and latches it onto an active-low battery-low output. A failing battery therefore stays reported until a later test passes. While main power is absent the block runs no tests, and it keeps the last result. The interval count restarts from zero at every test and whenever power is lost.

Top module: `batt_low_monitor`

## Requirements
- R1: While reset is applied, and after its release until a test produces a result, `batt_low_n` is 1 (no battery-low reported) and `sample_req` is 0.
- R2: When `pwr_ok` is sampled 1 at a rising edge while the block is unpowered (reset, or the last sampled `pwr_ok` was 0), `sample_req` is 1 for exactly the following clock cycle.
- R3: The comparator flag is read at the SETTLE_CYC-th rising edge after the edge that ends the strobe cycle. Before that edge `batt_low_n` keeps its old value.
- R4: At that read edge, `batt_below`=1 drives `batt_low_n` to 0, and `batt_below`=0 drives `batt_low_n` to 1.
- R5: Between read edges, `batt_low_n` holds its value whatever `batt_below` does.
- R6: After a test completes with power valid, the INTERVAL_TICKS-th clock cycle with `tick`=1 starts a new test: `sample_req` is 1 in the cycle after the edge that samples that tick, and 0 after every earlier tick.
- R7: A `tick` seen during a test (strobe or settle cycles) is not counted, and every test restarts the interval count from zero.
- R8: While `pwr_ok` is 0 no strobe is issued, even when the interval ends at that very edge. The partial interval count is discarded, so the next power-up test is followed by a full interval.
- R9: If `pwr_ok` is 0 at the strobe edge or the read edge, the test is abandoned and `batt_low_n` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_ok | input | 1 | 1 while main supply is within tolerance |
| tick | input | 1 | One-cycle slow time-base pulse that advances the interval count |
| batt_below | input | 1 | Comparator result, 1 when the battery is below threshold |
| batt_low_n | output | 1 | Latched battery-low indication, 0 means low |
| sample_req | output | 1 | One-cycle strobe that starts a comparator measurement |

## Verification
Two same-edge collisions matter. The first is the interval expiring at the edge where `pwr_ok` falls. The bench supplies the final tick together with a power drop and requires no strobe, followed by a power-up test and then a full fresh interval. The second is power failing at the read edge or at the strobe edge. The bench removes `pwr_ok` exactly one cycle before that edge and judges the outcome by a `batt_low_n` that has not moved. A sweep over every 4-bit sequence of comparator results runs periodic tests back to back and predicts each latched value from the bit under test. It toggles `batt_below` between tests, and ticks during settle cycles, to show that neither is taken.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    BM_OFF    = 2'd0,
    BM_STROBE = 2'd1,
    BM_SETTLE = 2'd2,
    BM_WAIT   = 2'd3
  } bm_state_e;
endpackage

// File: rtl/bm_interval.sv
// Counts slow ticks while enabled; pulses expire on the last one.
module bm_interval #(
  parameter int unsigned INTERVAL_TICKS = 86400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !run || tick;
  assign expire = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_expire_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/bm_settle.sv
// Holds off the comparator read for SETTLE_CYC cycles of the settle phase.
module bm_settle #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

  logic [SW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/batt_low_monitor.sv
module batt_low_monitor
  import bm_pkg::*;
#(
  parameter int unsigned INTERVAL_TICKS = 86400,
  parameter int unsigned SETTLE_CYC     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic tick,
  input  logic batt_below,
  output logic batt_low_n,
  output logic sample_req
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  bm_state_e state_q, state_d;
  logic      low_q, low_d, low_en;
  logic      settle_done, expire;

  bm_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .rst_n(rst_i_n),
    .run  (state_q == BM_SETTLE),
    .done (settle_done)
  );

  bm_interval #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_interval (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   ((state_q == BM_WAIT) && pwr_ok),
    .tick  (tick),
    .expire(expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BM_OFF:    if (pwr_ok) state_d = BM_STROBE;
      BM_STROBE: state_d = pwr_ok ? BM_SETTLE : BM_OFF;
      BM_SETTLE: if (!pwr_ok) state_d = BM_OFF;
                 else if (settle_done) state_d = BM_WAIT;
      BM_WAIT:   if (!pwr_ok) state_d = BM_OFF;
                 else if (expire) state_d = BM_STROBE;
      default:   state_d = BM_OFF;
    endcase
  end

  assign low_en = (state_q == BM_SETTLE) && settle_done && pwr_ok;
  assign low_d  = batt_below;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= BM_OFF;
      low_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (low_en) low_q <= low_d;
    end
  end

  assign batt_low_n = ~low_q;
  assign sample_req = (state_q == BM_STROBE);

  assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    sample_req |=> !sample_req);
  assert_no_strobe_unpowered_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pwr_ok |=> !sample_req);
  assert_flag_only_on_read_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(batt_low_n) |-> $past(settle_done && pwr_ok));
  assert_flag_follows_comparator_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (settle_done && pwr_ok) |=> (batt_low_n == !$past(batt_below)));
endmodule

// File: tb/sim_batt_low_monitor.sv
`timescale 1ns/1ps
module sim_batt_low_monitor;
  localparam int N = 5;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, tick, batt_below;
  logic batt_low_n, sample_req;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2 clk = ~clk;

  batt_low_monitor #(.INTERVAL_TICKS(N), .SETTLE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .tick(tick),
    .batt_below(batt_below), .batt_low_n(batt_low_n), .sample_req(sample_req)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Entry: just after the edge that raised the strobe, batt_below already set.
  task automatic run_test(input logic tick_in_settle);
    logic old;
    chk("R2 strobe", sample_req, 1'b1);
    old = batt_low_n;
    for (int i = 0; i < S; i++) begin
      tick = tick_in_settle;
      cyc();
      chk("R3 held before read", batt_low_n, old);
      chk("R2 single strobe", sample_req, 1'b0);
    end
    tick = 1'b0;
    cyc();
    chk("R4 result", batt_low_n, ~batt_below);
  endtask

  // Counts N ticks with idle cycles between them; ends at the new strobe.
  task automatic wait_interval(input logic next_below);
    logic held;
    held = batt_low_n;
    for (int t = 0; t < N; t++) begin
      batt_below = ~next_below;
      cyc();
      chk("R5 latched", batt_low_n, held);
      chk("R6 no early strobe", sample_req, 1'b0);
      batt_below = next_below;
      tick = 1'b1;
      cyc();
      tick = 1'b0;
      chk("R6 strobe on last tick", sample_req, (t == N - 1));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_ok = 1'b0; tick = 1'b0; batt_below = 1'b1;
    repeat (3) cyc();
    chk("R1 reset flag", batt_low_n, 1'b1);
    chk("R1 reset strobe", sample_req, 1'b0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 after release", batt_low_n, 1'b1);
    // R8: ticks without power produce nothing
    for (int i = 0; i < 2 * N; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
      chk("R8 unpowered", sample_req, 1'b0);
      chk("R1 no result yet", batt_low_n, 1'b1);
    end
    // R2: power-up test, battery low
    pwr_ok = 1'b1;
    cyc();
    run_test(1'b1);
    // R6 R7 R4: sweep every 4-bit result sequence
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 4; k++) begin
        wait_interval(p[k]);
        run_test(k[0]);
      end
    end
    // R8: partial count dropped by power loss
    for (int i = 0; i < N - 2; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
      chk("R6 partial", sample_req, 1'b0);
    end
    pwr_ok = 1'b0;
    cyc();
    chk("R8 loss no strobe", sample_req, 1'b0);
    batt_below = 1'b1;
    pwr_ok = 1'b1;
    cyc();
    run_test(1'b0);
    wait_interval(1'b0);
    run_test(1'b0);
    // R8: last tick and power drop at the same edge
    for (int i = 0; i < N - 1; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
    end
    tick = 1'b1; pwr_ok = 1'b0;
    cyc();
    tick = 1'b0;
    chk("R8 expiry vs power drop", sample_req, 1'b0);
    cyc();
    chk("R8 still none", sample_req, 1'b0);
    // R9: power lost at read edge keeps flag (currently 1)
    batt_below = 1'b1;
    pwr_ok = 1'b1;
    cyc();
    chk("R2 re-power", sample_req, 1'b1);
    for (int i = 0; i < S; i++) cyc();
    pwr_ok = 1'b0;
    cyc();
    chk("R9 read edge abandoned", batt_low_n, 1'b1);
    // R9: power lost at strobe edge
    pwr_ok = 1'b1;
    cyc();
    chk("R2 strobe again", sample_req, 1'b1);
    pwr_ok = 1'b0;
    for (int i = 0; i < S + 2; i++) begin
      cyc();
      chk("R9 strobe edge abandoned", batt_low_n, 1'b1);
    end
    // R1: reset clears a low flag
    pwr_ok = 1'b1;
    cyc();
    run_test(1'b0);
    chk("R4 low before reset", batt_low_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset flag", batt_low_n, 1'b1);
    chk("R1 async reset strobe", sample_req, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule